// File: doc/BRIEF.md
# Low-Power Wake-Up Controller

This block decides when a device may drop into its suspend or sleep state and when it must come back out. Software drives it through one 16-bit control/status word. A single write to that word both arms a chosen set of wake sources and asks for a low-power state. The arming is one-shot: it is used up by the next wake, so every entry needs a new write.

Six single-cycle event inputs and an active-low reset pin are watched all the time. Each has a sticky flag, and a flag is set whether or not its source is armed. While the device is in a low-power state, an armed event wakes it. A falling edge on the reset pin wakes it in every case. The block refuses an entry request if a flag of a source named in that request is still set. After every reset-pin fall it also refuses entry for a fixed hold-off time, sized from the clock frequency. A refused request sets a sticky error bit.

Top module: `wake_ctrl`

## Requirements
- R1: After synchronous reset the state is awake (`pm_state_o` = 00), `reg_rdata` reads 0 and `wake_o` is 0.
- R2: A high level on `evt_i[i]` in a cycle sets flag i (read at `reg_rdata[8+i]`), whether or not source i is armed. The flag stays set until it is cleared.
- R3: Writing 1 to `reg_wdata[8+i]` clears flag i, and writing 1 to bit 6 clears the pin flag. If an event arrives in the same cycle as its clear, the event wins and the flag stays set.
- R4: A write with bit 14 requests suspend (`pm_state_o` = 01, read bit 14). A write with bit 15 requests sleep (10, read bit 15). If both bits are set, sleep wins. The arm mask `reg_wdata[5:0]` is loaded (read at `reg_rdata[5:0]`) only by an entry that is accepted. A write without a request bit leaves the arm mask at 0.
- R5: An entry request is refused (the state stays awake) when the requested arm mask and the current flags share any set bit. A refusal sets the error bit (read bit 7), which stays set until 1 is written to bit 7.
- R6: In suspend or sleep, an event on an armed source returns the block to awake at that clock edge. It raises `wake_o` for exactly one cycle and clears the arm mask. An event on a source that is not armed only sets its flag.
- R7: A falling edge on `rst_pin_n`, taken through a two-flop synchronizer, wakes the block from either low-power state whatever the arm mask holds. It also sets the pin flag (read bit 6).
- R8: After a synchronized reset-pin fall, entry requests are refused for HOLD_CYC = CLK_MHZ*HOLD_US cycles. A request sampled d cycles after the wake edge is refused for d < HOLD_CYC and accepted for d >= HOLD_CYC.
- R9: After a wake caused by an event, there is no minimum awake time. The first entry request that follows is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 16 | Write data: arm mask, W1C bits, mode requests |
| reg_rdata | output | 16 | Status: arm mask, flags, error, current state |
| evt_i | input | N_SRC | Single-cycle wake event pulses |
| rst_pin_n | input | 1 | Asynchronous active-low reset pin |
| wake_o | output | 1 | One-cycle pulse on each wake |
| pm_state_o | output | 2 | 00 awake, 01 suspend, 10 sleep |

## Verification
The wake path is tried with every 6-bit arm mask crossed with each single event source, in all three request encodings. This shows that a wake follows only the armed bit, and it separates a suspend-or-sleep priority error from a masking error. The refusal path uses the same mask-by-flag cross, so a flag that blocks entry is told apart from one that is merely set. Reset-pin wakes are tried with an empty mask from both states. Re-entry is then timed at delays just below, at and just above the hold-off length, which catches an off-by-one counter.

// File: rtl/wake_pkg.sv
// Package wake_pkg
// Shared state encoding and control-word bit positions for the wake-up
// controller. Assumes at most six event sources fit in the word.
package wake_pkg;
    typedef enum logic [1:0] {
        PM_AWAKE   = 2'b00,
        PM_SUSPEND = 2'b01,
        PM_SLEEP   = 2'b10
    } pm_state_t;

    localparam int REG_W     = 16;
    localparam int ARM_LSB   = 0;
    localparam int PIN_BIT   = 6;
    localparam int ERR_BIT   = 7;
    localparam int FLG_LSB   = 8;
    localparam int SUSP_BIT  = 14;
    localparam int SLEEP_BIT = 15;
endpackage

// File: rtl/wake_pin_sync.sv
// Module wake_pin_sync
// Brings the asynchronous active-low reset pin into the clock domain with two
// flops, then flags one cycle per falling edge. Assumes the pin idles high.
module wake_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall_o
);
    logic sync1, sync2, prev;

    // Two-stage synchronizer plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
            prev  <= 1'b1;
        end else begin
            sync1 <= pin_n;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    assign fall_o = prev & ~sync2;

    // R7: one synchronized fall never spans two cycles.
    a_r7_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/wake_flags.sv
// Module wake_flags
// Bank of sticky flags. A set request wins over a same-cycle clear request.
// Assumes set and clear are single-cycle qualified strobes.
module wake_flags #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flags_o
);
    for (genvar g = 0; g < W; g++) begin : g_flag
        // One sticky bit: set on its event, cleared on its W1C strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags_o[g] <= 1'b0;
            else if (set_i[g])
                flags_o[g] <= 1'b1;
            else if (clr_i[g])
                flags_o[g] <= 1'b0;
        end

        // R2: an event always leaves its flag set.
        a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> flags_o[g]);
        // R3: a clear without a colliding event drops the flag.
        a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !flags_o[g]);
    end
endmodule

// File: rtl/wake_holdoff.sv
// Module wake_holdoff
// Down-counter that blocks low-power entry for HOLD_CYC cycles after each
// start pulse. A new start reloads the full window. Assumes HOLD_CYC >= 1.
module wake_holdoff #(
    parameter int HOLD_CYC = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(HOLD_CYC);

    logic [CW-1:0] cnt;

    // Load on start, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start_i)
            cnt <= LOAD;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy_o = (cnt != '0);

    // R8: a start always opens the window.
    a_r8_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);
    // R8: the window shrinks by exactly one per cycle.
    a_r8_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !start_i) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/wake_mode_fsm.sv
// Module wake_mode_fsm
// Tracks awake/suspend/sleep, accepts or refuses entry requests, holds the
// one-shot arm mask and the sticky refusal error, and emits the wake pulse.
// Assumes requests arrive as qualified single-cycle write strobes.
module wake_mode_fsm
    import wake_pkg::*;
#(
    parameter int N_SRC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             req_sleep_i,
    input  logic             req_susp_i,
    input  logic [N_SRC-1:0] req_arm_i,
    input  logic             err_clr_i,
    input  logic [N_SRC-1:0] flags_i,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             pin_fall_i,
    input  logic             hold_busy_i,
    output pm_state_t        state_o,
    output logic [N_SRC-1:0] arm_o,
    output logic             err_o,
    output logic             wake_o
);
    logic req, blocked, enter_ok, refused, wake_hit;

    assign req      = wr_i & (req_sleep_i | req_susp_i);
    assign blocked  = (|(req_arm_i & flags_i)) | hold_busy_i | pin_fall_i;
    assign enter_ok = (state_o == PM_AWAKE) & req & ~blocked;
    assign refused  = (state_o == PM_AWAKE) & req & blocked;
    assign wake_hit = (state_o != PM_AWAKE) & ((|(evt_i & arm_o)) | pin_fall_i);

    // State and arm mask: load both on entry, drop to awake and disarm on wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o <= PM_AWAKE;
            arm_o   <= '0;
        end else if (enter_ok) begin
            state_o <= req_sleep_i ? PM_SLEEP : PM_SUSPEND;
            arm_o   <= req_arm_i;
        end else if (wake_hit) begin
            state_o <= PM_AWAKE;
            arm_o   <= '0;
        end
    end

    // Registered one-cycle wake pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_o <= 1'b0;
        else        wake_o <= wake_hit;
    end

    // Sticky refusal error; a new refusal wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         err_o <= 1'b0;
        else if (refused)   err_o <= 1'b1;
        else if (err_clr_i) err_o <= 1'b0;
    end

    // R5: a pending flag on a requested source blocks entry and raises error.
    a_r5_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == PM_AWAKE && req && |(req_arm_i & flags_i)) |=>
        (state_o == PM_AWAKE && err_o));
    // R8: no entry while the hold-off window is open.
    a_r8_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == PM_AWAKE && req && hold_busy_i) |=> (state_o == PM_AWAKE));
    // R7: a pin fall always wakes a low-power state.
    a_r7_pin_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != PM_AWAKE && pin_fall_i) |=> (state_o == PM_AWAKE && wake_o));
    // R6: a wake pulse coincides with an awake, disarmed block.
    a_r6_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (state_o == PM_AWAKE && arm_o == '0));
    // R6: the wake pulse lasts one cycle.
    a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);
    // R4: sleep wins when both request bits are written.
    a_r4_sleep_prio: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == PM_AWAKE && req_sleep_i && req_susp_i && wr_i && !blocked) |=>
        (state_o == PM_SLEEP));
endmodule

// File: rtl/wake_ctrl.sv
// Module wake_ctrl
// Top of the wake-up controller: control/status word, sticky flags for N_SRC
// events plus the reset pin, hold-off after pin wakes, and the mode FSM.
// Assumes N_SRC <= 6 and HOLD_CYC = CLK_MHZ*HOLD_US >= 1.
module wake_ctrl
    import wake_pkg::*;
#(
    parameter int N_SRC   = 6,
    parameter int CLK_MHZ = 20,
    parameter int HOLD_US = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             rst_pin_n,
    output logic             wake_o,
    output logic [1:0]       pm_state_o
);
    localparam int HOLD_CYC = CLK_MHZ * HOLD_US;
    localparam int FW       = N_SRC + 1;

    logic             pin_fall;
    logic             hold_busy;
    logic [FW-1:0]    flag_set, flag_clr, flags;
    logic [N_SRC-1:0] arm;
    logic             err;
    pm_state_t        state;

    wake_pin_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_n  (rst_pin_n),
        .fall_o (pin_fall)
    );

    // Flag bank inputs: top bit is the reset-pin flag.
    assign flag_set = {pin_fall, evt_i};
    assign flag_clr = reg_wr ? {reg_wdata[PIN_BIT], reg_wdata[FLG_LSB +: N_SRC]} : '0;

    wake_flags #(.W(FW)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (flag_set),
        .clr_i   (flag_clr),
        .flags_o (flags)
    );

    wake_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (pin_fall),
        .busy_o  (hold_busy)
    );

    wake_mode_fsm #(.N_SRC(N_SRC)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (reg_wr),
        .req_sleep_i (reg_wdata[SLEEP_BIT]),
        .req_susp_i  (reg_wdata[SUSP_BIT]),
        .req_arm_i   (reg_wdata[ARM_LSB +: N_SRC]),
        .err_clr_i   (reg_wr & reg_wdata[ERR_BIT]),
        .flags_i     (flags[N_SRC-1:0]),
        .evt_i       (evt_i),
        .pin_fall_i  (pin_fall),
        .hold_busy_i (hold_busy),
        .state_o     (state),
        .arm_o       (arm),
        .err_o       (err),
        .wake_o      (wake_o)
    );

    // Assemble the status view of the control word.
    always_comb begin
        reg_rdata                   = '0;
        reg_rdata[ARM_LSB +: N_SRC] = arm;
        reg_rdata[PIN_BIT]          = flags[N_SRC];
        reg_rdata[ERR_BIT]          = err;
        reg_rdata[FLG_LSB +: N_SRC] = flags[N_SRC-1:0];
        reg_rdata[SUSP_BIT]         = (state == PM_SUSPEND);
        reg_rdata[SLEEP_BIT]        = (state == PM_SLEEP);
    end

    assign pm_state_o = state;

    // R4: the state output never shows the unused encoding.
    a_r4_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
        pm_state_o != 2'b11);
endmodule

// File: tb/tb_wake_ctrl.sv
module tb_wake_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NS   = 6;
    localparam int MHZ  = 20;
    localparam int US   = 15;
    localparam int HOLD = MHZ * US;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic [NS-1:0] evt = '0;
    logic          pin = 1'b1;
    logic          wake;
    logic [1:0]    pm;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wake_ctrl #(.N_SRC(NS), .CLK_MHZ(MHZ), .HOLD_US(US)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .evt_i      (evt),
        .rst_pin_n  (pin),
        .wake_o     (wake),
        .pm_state_o (pm)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [NS-1:0] e);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic pin_wake(output bit seen);
        seen = 1'b0;
        pin = 1'b0;
        for (int k = 0; k < 8 && !seen; k++) begin
            @(negedge clk);
            if (wake) seen = 1'b1;
        end
        pin = 1'b1;
    endtask

    function automatic int lowbit(input logic [NS-1:0] m);
        for (int b = NS - 1; b >= 0; b--) if (m[b]) lowbit = b;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL R1 watchdog: act=running exp=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        bit seen;
        int ds[6];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 rdata", reg_rdata, 16'h0000);
        chk("R1 state", {14'd0, pm}, 16'd0);
        chk("R1 wake", {15'd0, wake}, 16'd0);

        // R2: flags collect events with nothing armed.
        for (int i = 0; i < NS; i++) begin
            pulse(6'(1 << i));
            chk("R2 flag accumulates", {10'd0, reg_rdata[13:8]}, 16'((1 << (i + 1)) - 1));
            chk("R2 stays awake", {14'd0, pm}, 16'd0);
        end
        // R3: clear colliding with an event keeps the flag; plain clear drops it.
        evt = 6'h01;
        wr(16'h0100);
        evt = '0;
        chk("R3 event wins", {10'd0, reg_rdata[13:8]}, 16'h003F);
        wr(16'h0100);
        chk("R3 w1c", {10'd0, reg_rdata[13:8]}, 16'h003E);
        wr(16'h3E00);
        chk("R3 clear all", {10'd0, reg_rdata[13:8]}, 16'h0000);
        // R4: arm bits without a request are ignored.
        wr(16'h003F);
        chk("R4 no request", reg_rdata, 16'h0000);

        // R6/R4/R7 sweep: every arm mask against each event source.
        for (int m = 0; m < 64; m++) begin
            for (int i = 0; i < NS; i++) begin
                int mode;
                logic [15:0] w;
                logic [1:0] exp_st;
                mode = (m + i) % 3;
                w = (mode == 0) ? 16'h4000 : (mode == 1) ? 16'h8000 : 16'hC000;
                exp_st = (mode == 0) ? 2'b01 : 2'b10;
                wr(16'h3FC0);
                wr(w | 16'(m));
                chk("R4 entry state", {14'd0, pm}, {14'd0, exp_st});
                chk("R4 arm loaded", {10'd0, reg_rdata[5:0]}, 16'(m));
                pulse(6'(1 << i));
                if (m[i]) begin
                    chk("R6 armed wake", {13'd0, wake, pm}, 16'h0004);
                    chk("R6 disarmed", {10'd0, reg_rdata[5:0]}, 16'd0);
                    @(negedge clk);
                    chk("R6 one-cycle pulse", {15'd0, wake}, 16'd0);
                end else begin
                    chk("R6 unarmed holds", {14'd0, pm}, {14'd0, exp_st});
                    chk("R2 unarmed flag", {15'd0, reg_rdata[8 + i]}, 16'd1);
                    if (m != 0) begin
                        pulse(6'(1 << lowbit(6'(m))));
                        chk("R6 other armed wake", {14'd0, pm}, 16'd0);
                    end else begin
                        pin_wake(seen);
                        chk("R7 pin wake", {15'd0, seen}, 16'd1);
                        chk("R7 pin awake", {14'd0, pm}, 16'd0);
                        chk("R7 pin flag", {15'd0, reg_rdata[6]}, 16'd1);
                        repeat (HOLD + 4) @(negedge clk);
                    end
                end
            end
        end

        // R5 sweep: one set flag against every nonzero requested mask.
        for (int i = 0; i < NS; i++) begin
            for (int m = 1; m < 64; m++) begin
                wr(16'h3FC0);
                pulse(6'(1 << i));
                wr(16'h8000 | 16'(m));
                if (m[i]) begin
                    chk("R5 refused", {14'd0, pm}, 16'd0);
                    chk("R5 error set", {15'd0, reg_rdata[7]}, 16'd1);
                end else begin
                    chk("R5 accepted", {14'd0, pm}, 16'd2);
                    chk("R5 no error", {15'd0, reg_rdata[7]}, 16'd0);
                    pulse(6'(1 << lowbit(6'(m))));
                end
            end
        end
        wr(16'h2000);
        pulse(6'h20);
        wr(16'h8020);
        chk("R5 sticky", {15'd0, reg_rdata[7]}, 16'd1);
        wr(16'h3F00);
        chk("R5 sticky after flag clear", {15'd0, reg_rdata[7]}, 16'd1);
        wr(16'h0080);
        chk("R5 err w1c", {15'd0, reg_rdata[7]}, 16'd0);

        // R9: no hold-off after an event wake.
        wr(16'h3FC0);
        wr(16'h8001);
        pulse(6'h01);
        wr(16'h0100);
        wr(16'h4002);
        chk("R9 immediate reentry", {14'd0, pm}, 16'd1);
        pulse(6'h02);

        // R8: re-entry timing around the hold-off boundary.
        ds = '{0, 1, HOLD - 2, HOLD - 1, HOLD, HOLD + 1};
        for (int k = 0; k < 6; k++) begin
            repeat (HOLD + 4) @(negedge clk);
            wr(16'h3FC0);
            wr(16'h8001);
            chk("R8 setup entry", {14'd0, pm}, 16'd2);
            pin_wake(seen);
            chk("R7 pin wake from sleep", {15'd0, seen}, 16'd1);
            repeat (ds[k]) @(negedge clk);
            wr(16'h8001);
            if (ds[k] >= HOLD) begin
                chk("R8 accepted after window", {14'd0, pm}, 16'd2);
                pulse(6'h01);
            end else begin
                chk("R8 refused in window", {14'd0, pm}, 16'd0);
                chk("R8 error in window", {15'd0, reg_rdata[7]}, 16'd1);
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule